// File: doc/BRIEF.md
# Hologram Source Parameter Calculator

This block prepares the per-source constants for a row-parallel hologram engine. A single point light source arrives on a valid/ready input: lateral offsets x and y relative to the reference pixel of the current row, an integer depth z and an amplitude. From these the block derives four phase terms that every pixel of the row uses. Because these terms are incremental, the pixel units downstream only add and never need a square root or a division. All phases are unsigned fractions of one turn, and whole turns are discarded.

The block computes the shared factor K/z, where K stands for p²/(2·λ) scaled to phase units, with a restoring divider that produces one quotient bit per clock. It multiplies that quotient by the lateral terms. Sources are handled strictly one after another, and the input stays not-ready until the current result has been emitted. The pixel pitch and the wavelength enter only through two compile-time constants. `K_NUM` is the numerator of K/z. `K_DEPTH` is 1/λ in turns per depth unit, scaled by 2^PH_W.

The controller has four states. IDLE holds `src_ready` high. On a handshake with a nonzero depth it takes the transition *accept* to DIVIDE. On a handshake with zero depth it takes the transition *reject*: it stays in IDLE and pulses the error flag. DIVIDE lasts N_W cycles and takes the transition *quotient done* to MULTIPLY. MULTIPLY registers the results and takes the transition *load* to EMIT. EMIT raises `prm_valid` for one cycle and takes the transition *release* back to IDLE.

Top module: `src_phase_prep`

## Requirements
- R1: While `rst_n` is low, `src_ready` is 1, `prm_valid` is 0 and `zero_err` is 0.
- R2: `prm_depth` equals (z·K_DEPTH) mod 2^PH_W.
- R3: `prm_step2` equals floor(K_NUM/z) mod 2^PH_W.
- R4: `prm_step1` equals floor(K_NUM/z)·(2x+1) mod 2^PH_W, where x is a two's-complement signed offset.
- R5: `prm_base` equals floor(K_NUM/z)·(x²+y²) mod 2^PH_W, where x and y are two's-complement signed offsets.
- R6: `prm_amp` equals the amplitude of the same source, is valid together with `prm_valid`, and holds until the next result.
- R7: Take a source accepted at clock edge t. `prm_valid` is high for exactly one cycle, the cycle that follows edge t+N_W+1.
- R8: `src_ready` is low from the edge that accepts a nonzero-depth source until edge t+N_W+2. A source offered while `src_ready` is low is ignored and does not alter the pending result.
- R9: A handshake with z = 0 raises `zero_err` for the single following cycle. It produces no `prm_valid`, and `src_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Source offered |
| src_ready | output | 1 | Block can take a source |
| src_x | input | X_W | Signed x offset from the reference pixel |
| src_y | input | X_W | Signed y offset |
| src_z | input | Z_W | Unsigned depth, nonzero |
| src_amp | input | A_W | Source amplitude |
| prm_valid | output | 1 | Parameter bundle valid, one-cycle pulse |
| prm_depth | output | PH_W | Depth phase, turns |
| prm_base | output | PH_W | Lateral phase at offset zero, turns |
| prm_step1 | output | PH_W | First-step increment, turns |
| prm_step2 | output | PH_W | Second-order increment, turns |
| prm_amp | output | A_W | Amplitude passed through |
| zero_err | output | 1 | Pulse for a rejected zero-depth source |

## Verification
Take a nonzero source accepted at edge t. The result fields and `prm_valid` become visible after edge t+N_W+1, and `src_ready` returns after edge t+N_W+2. A zero-depth source shows `zero_err` directly after its accepting edge. The bench keeps a behavioural countdown of the remaining busy cycles and a record of the pending expected bundle. At every falling edge it compares ready, valid and error against that countdown, and it compares the data fields in the one cycle where the countdown says the result is due. Sources offered during the busy window are therefore checked implicitly: they must leave the countdown and the pending bundle unchanged.

// File: rtl/spp_pkg.sv
package spp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DIVIDE   = 2'd1,
        ST_MULTIPLY = 2'd2,
        ST_EMIT     = 2'd3
    } spp_state_e;

endpackage

// File: rtl/spp_divider.sv
// Restoring divider: computes NUM / divisor, producing one quotient bit per clock.
module spp_divider #(
    parameter int              N_W = 24,
    parameter int              D_W = 12,
    parameter logic [N_W-1:0]  NUM = 24'd9000000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [D_W-1:0] divisor,
    output logic           last,
    output logic [N_W-1:0] quot
);
    localparam int CNT_W = $clog2(N_W + 1);

    logic [D_W-1:0]   rem;
    logic [D_W-1:0]   dvs;
    logic [N_W-1:0]   sh;
    logic [CNT_W-1:0] cnt;
    logic [D_W:0]     trial;
    logic [D_W:0]     diff;
    logic             fits;

    always_comb begin
        trial = {rem, sh[N_W-1]};
        diff  = trial - {1'b0, dvs};
        fits  = (trial >= {1'b0, dvs});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
            dvs <= '0;
            sh  <= '0;
            cnt <= '0;
        end else if (start) begin
            rem <= '0;
            dvs <= divisor;
            sh  <= NUM;
            cnt <= CNT_W'(N_W);
        end else if (cnt != '0) begin
            rem <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
            sh  <= {sh[N_W-2:0], fits};
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == CNT_W'(1));
    assign quot = sh;

endmodule

// File: rtl/spp_phase_mul.sv
// Forms the phase terms from the quotient and the lateral offsets, modulo one turn.
module spp_phase_mul #(
    parameter int               PH_W    = 16,
    parameter int               X_W     = 10,
    parameter int               Z_W     = 12,
    parameter int               N_W     = 24,
    parameter logic [PH_W-1:0]  K_DEPTH = 16'd40503
) (
    input  logic [N_W-1:0]        quot,
    input  logic signed [X_W-1:0] x,
    input  logic signed [X_W-1:0] y,
    input  logic [Z_W-1:0]        z,
    output logic [PH_W-1:0]       depth_ph,
    output logic [PH_W-1:0]       base_ph,
    output logic [PH_W-1:0]       step1_ph,
    output logic [PH_W-1:0]       step2_ph
);
    localparam int PW = N_W + 2 * X_W + Z_W + 4;

    logic signed [PW-1:0] xe, ye, qe, ze, kd;
    logic signed [PW-1:0] radial, odd, p_base, p_step1, p_depth;

    always_comb begin
        xe      = PW'(x);
        ye      = PW'(y);
        qe      = PW'(quot);
        ze      = PW'(z);
        kd      = PW'(K_DEPTH);
        radial  = xe * xe + ye * ye;
        odd     = xe + xe + PW'(1);
        p_base  = qe * radial;
        p_step1 = qe * odd;
        p_depth = ze * kd;
    end

    assign depth_ph = p_depth[PH_W-1:0];
    assign base_ph  = p_base[PH_W-1:0];
    assign step1_ph = p_step1[PH_W-1:0];
    assign step2_ph = quot[PH_W-1:0];

endmodule

// File: rtl/src_phase_prep.sv
module src_phase_prep
    import spp_pkg::*;
#(
    parameter int               PH_W    = 16,
    parameter int               X_W     = 10,
    parameter int               Z_W     = 12,
    parameter int               A_W     = 8,
    parameter int               N_W     = 24,
    parameter logic [N_W-1:0]   K_NUM   = 24'd9000000,
    parameter logic [PH_W-1:0]  K_DEPTH = 16'd40503
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  src_valid,
    output logic                  src_ready,
    input  logic signed [X_W-1:0] src_x,
    input  logic signed [X_W-1:0] src_y,
    input  logic [Z_W-1:0]        src_z,
    input  logic [A_W-1:0]        src_amp,
    output logic                  prm_valid,
    output logic [PH_W-1:0]       prm_depth,
    output logic [PH_W-1:0]       prm_base,
    output logic [PH_W-1:0]       prm_step1,
    output logic [PH_W-1:0]       prm_step2,
    output logic [A_W-1:0]        prm_amp,
    output logic                  zero_err
);
    spp_state_e state, state_nx;

    logic                  take;
    logic                  accept;
    logic                  reject;
    logic                  div_last;
    logic [N_W-1:0]        quot;
    logic signed [X_W-1:0] lx, ly;
    logic [Z_W-1:0]        lz;
    logic [A_W-1:0]        lamp;
    logic [PH_W-1:0]       c_depth, c_base, c_step1, c_step2;

    assign take   = src_valid && (state == ST_IDLE);
    assign accept = take && (src_z != '0);
    assign reject = take && (src_z == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept)   state_nx = ST_DIVIDE;
            ST_DIVIDE:   if (div_last) state_nx = ST_MULTIPLY;
            ST_MULTIPLY:               state_nx = ST_EMIT;
            ST_EMIT:                   state_nx = ST_IDLE;
        endcase
    end

    // outputs and captured source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lx        <= '0;
            ly        <= '0;
            lz        <= '0;
            lamp      <= '0;
            prm_valid <= 1'b0;
            prm_depth <= '0;
            prm_base  <= '0;
            prm_step1 <= '0;
            prm_step2 <= '0;
            prm_amp   <= '0;
            zero_err  <= 1'b0;
        end else begin
            zero_err  <= reject;
            prm_valid <= (state == ST_MULTIPLY);
            if (accept) begin
                lx   <= src_x;
                ly   <= src_y;
                lz   <= src_z;
                lamp <= src_amp;
            end
            if (state == ST_MULTIPLY) begin
                prm_depth <= c_depth;
                prm_base  <= c_base;
                prm_step1 <= c_step1;
                prm_step2 <= c_step2;
                prm_amp   <= lamp;
            end
        end
    end

    assign src_ready = (state == ST_IDLE);

    spp_divider #(
        .N_W (N_W),
        .D_W (Z_W),
        .NUM (K_NUM)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .divisor (src_z),
        .last    (div_last),
        .quot    (quot)
    );

    spp_phase_mul #(
        .PH_W    (PH_W),
        .X_W     (X_W),
        .Z_W     (Z_W),
        .N_W     (N_W),
        .K_DEPTH (K_DEPTH)
    ) u_mul (
        .quot     (quot),
        .x        (lx),
        .y        (ly),
        .z        (lz),
        .depth_ph (c_depth),
        .base_ph  (c_base),
        .step1_ph (c_step1),
        .step2_ph (c_step2)
    );

endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
    parameter int PH_W = 16,
    parameter int X_W  = 10,
    parameter int Z_W  = 12,
    parameter int A_W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  src_valid,
    input logic                  src_ready,
    input logic signed [X_W-1:0] src_x,
    input logic signed [X_W-1:0] src_y,
    input logic [Z_W-1:0]        src_z,
    input logic [A_W-1:0]        src_amp,
    input logic                  prm_valid,
    input logic [PH_W-1:0]       prm_depth,
    input logic [PH_W-1:0]       prm_base,
    input logic [PH_W-1:0]       prm_step1,
    input logic [PH_W-1:0]       prm_step2,
    input logic [A_W-1:0]        prm_amp,
    input logic                  zero_err
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |-> (src_ready && !prm_valid && !zero_err));

    assert_amp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prm_valid |=> $stable(prm_amp));

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        prm_valid |=> !prm_valid);

    assert_busy_on_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prm_valid |-> !src_ready);

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && src_z != '0) |=> !src_ready);

    assert_reject_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && src_z == '0) |=> (zero_err && src_ready));

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_err |=> !zero_err);

    assert_err_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zero_err |-> !prm_valid);
endmodule

bind src_phase_prep spp_checker #(
    .PH_W (PH_W),
    .X_W  (X_W),
    .Z_W  (Z_W),
    .A_W  (A_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .src_x     (src_x),
    .src_y     (src_y),
    .src_z     (src_z),
    .src_amp   (src_amp),
    .prm_valid (prm_valid),
    .prm_depth (prm_depth),
    .prm_base  (prm_base),
    .prm_step1 (prm_step1),
    .prm_step2 (prm_step2),
    .prm_amp   (prm_amp),
    .zero_err  (zero_err)
);

// File: tb/src_phase_prep_bench.sv
module src_phase_prep_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PH_W = 16;
    localparam int X_W  = 10;
    localparam int Z_W  = 12;
    localparam int A_W  = 8;
    localparam int N_W  = 24;
    localparam longint KN = 9000000;
    localparam longint KD = 40503;
    localparam longint MASK = (64'd1 << PH_W) - 1;

    logic clk = 1'b0;
    logic rst_n;
    logic src_valid;
    logic src_ready;
    logic signed [X_W-1:0] src_x, src_y;
    logic [Z_W-1:0] src_z;
    logic [A_W-1:0] src_amp;
    logic prm_valid;
    logic [PH_W-1:0] prm_depth, prm_base, prm_step1, prm_step2;
    logic [A_W-1:0] prm_amp;
    logic zero_err;

    int checks = 0;
    int fails  = 0;
    bit run_cmp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    src_phase_prep #(
        .PH_W(PH_W), .X_W(X_W), .Z_W(Z_W), .A_W(A_W), .N_W(N_W),
        .K_NUM(24'd9000000), .K_DEPTH(16'd40503)
    ) u_src_phase_prep (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_ready(src_ready),
        .src_x(src_x), .src_y(src_y), .src_z(src_z), .src_amp(src_amp),
        .prm_valid(prm_valid), .prm_depth(prm_depth), .prm_base(prm_base),
        .prm_step1(prm_step1), .prm_step2(prm_step2), .prm_amp(prm_amp),
        .zero_err(zero_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: countdown of busy cycles and a pending bundle
    int     mcnt;
    bit     e_err;
    longint e_depth, e_base, e_step1, e_step2, e_amp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt  <= 0;
            e_err <= 1'b0;
        end else begin
            e_err <= (mcnt == 0 && src_valid && src_z == 0);
            if (mcnt == 0 && src_valid && src_z != 0) begin
                longint q, xi, yi;
                q  = KN / longint'(src_z);
                xi = longint'(src_x);
                yi = longint'(src_y);
                mcnt    <= N_W + 2;
                e_depth <= (longint'(src_z) * KD) & MASK;
                e_step2 <= q & MASK;
                e_step1 <= (q * (2 * xi + 1)) & MASK;
                e_base  <= (q * (xi * xi + yi * yi)) & MASK;
                e_amp   <= longint'(src_amp);
            end else if (mcnt > 0) begin
                mcnt <= mcnt - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 ready in reset", longint'(src_ready), 1);
            chk("R1 valid in reset", longint'(prm_valid), 0);
            chk("R1 err in reset",   longint'(zero_err), 0);
        end else if (run_cmp) begin
            chk("R8 ready",  longint'(src_ready), longint'(mcnt == 0));
            chk("R7 valid",  longint'(prm_valid), longint'(mcnt == 1));
            chk("R9 err",    longint'(zero_err),  longint'(e_err));
            if (mcnt == 1) begin
                chk("R2 depth", longint'(prm_depth), e_depth);
                chk("R3 step2", longint'(prm_step2), e_step2);
                chk("R4 step1", longint'(prm_step1), e_step1);
                chk("R5 base",  longint'(prm_base),  e_base);
                chk("R6 amp",   longint'(prm_amp),   e_amp);
            end
        end
    end

    task automatic drive(input int x, input int y, input int z, input int a);
        src_x   = X_W'(x);
        src_y   = X_W'(y);
        src_z   = Z_W'(z);
        src_amp = A_W'(a);
    endtask

    task automatic send(input int x, input int y, input int z, input int a);
        while (!src_ready) @(negedge clk);
        drive(x, y, z, a);
        src_valid = 1'b1;
        @(negedge clk);
        src_valid = 1'b0;
        while (!src_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        src_valid = 1'b0;
        drive(0, 0, 1, 0);
        repeat (3) @(negedge clk);
        rst_n   = 1'b1;
        run_cmp = 1'b1;
        @(negedge clk);

        // R2-R6 across distinct patterns, including extreme offsets and depths
        send(0, 0, 1, 8'h11);
        send(5, -3, 100, 8'hA5);
        send(-512, 511, 4095, 8'hFF);
        send(511, -512, 7, 8'h01);
        send(-1, -1, 2, 8'h80);
        send(37, 200, 1234, 8'h3C);

        // R9: zero depth rejected, a valid source directly after is accepted
        while (!src_ready) @(negedge clk);
        drive(9, 9, 0, 8'h55);
        src_valid = 1'b1;
        @(negedge clk);
        drive(-20, 15, 50, 8'h66);
        @(negedge clk);
        src_valid = 1'b0;
        while (!src_ready) @(negedge clk);
        @(negedge clk);

        // R8: offers during busy window are ignored
        while (!src_ready) @(negedge clk);
        drive(3, 4, 9, 8'h77);
        src_valid = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            drive(100 + i, -50 - i, i, 8'h20 + i);
        end
        src_valid = 1'b0;
        while (!src_ready) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule